// File: doc/BRIEF.md
# Staging buffer access arbiter with engine lockout

The block holds two message staging buffers, an inbound buffer and an outbound buffer. Two requesters share them. A CPU register port reads and writes single bytes, halfwords or words. A transfer engine copies data between the buffers and system memory without CPU involvement, and it moves data only in bursts of four 32-bit words. The engine always wins. While the engine is switched on, or while one of its bursts is still running, the CPU is shut out. A refused CPU write is dropped, a refused CPU read returns zero, and a sticky error flag raises the interrupt line.

The engine presents one beat per cycle. Each beat carries a 2-bit beat number and a last-beat marker, and the burst address stays fixed for the whole burst. If a burst breaks sequence, the block drops that beat, raises a separate sticky protocol error flag and resets its burst tracker. Software clears either flag by pulsing its bit on the clear input.

Top module: `stage_buf_arbiter`

## Requirements
- R1: When the CPU is not locked out, an aligned CPU write updates only its byte lanes. The data sits in bus lane position. A byte access at byte offset k enables lane k. A halfword access enables lanes 0–1 at offset 0 and lanes 2–3 at offset 2. A word access enables all four lanes. On cpu_size_i, 0 means byte, 1 halfword, 2 word and 3 reserved. A CPU read returns the whole addressed 32-bit word, with cpu_rvalid_o high, in the cycle after the request.
- R2: The block refuses a misaligned CPU access. This covers a halfword at an odd offset, a word at a nonzero offset, and any access with size 3. A refused write changes no buffer, a refused read returns zero, and cpu_err_o is set.
- R3: While xfer_en_i is high, every CPU access is refused. Buffer contents stay unchanged, reads return zero and cpu_err_o is set.
- R4: cpu_err_o stays set until err_clr_i[0] is pulsed. A refusal in the same cycle as the clear keeps the flag set. irq_o is the OR of cpu_err_o and proto_err_o.
- R5: An engine beat writes or reads word eng_addr_i[5:2]*4 + eng_beat_i of the buffer chosen by eng_sel_i (0 = inbound, 1 = outbound). Engine read data appears on eng_rdata_o in the cycle after the beat.
- R6: The following beats are protocol errors: a beat number that differs from the expected one, a last marker that does not coincide with beat 3, and an address whose low two bits are nonzero. Each sets proto_err_o, is itself dropped and resets the tracker to expect beat 0. Earlier good beats of that burst stay written.
- R7: Once a burst has started, the CPU stays locked out until its last beat, even after xfer_en_i falls. After the last beat the CPU has access again.
- R8: A CPU access in the same cycle as an engine beat is refused, even with xfer_en_i low.
- R9: proto_err_o stays set until err_clr_i[1] is pulsed.
- R10: After reset both buffers hold zero, both error flags and irq_o are low, and cpu_rvalid_o and cpu_rdata_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_en_i | input | 1 | Transfer engine switched on |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU write (1) or read (0) |
| cpu_sel_i | input | 1 | CPU buffer select: 0 inbound, 1 outbound |
| cpu_addr_i | input | 8 | CPU byte address |
| cpu_size_i | input | 2 | Access size: 0 byte, 1 half, 2 word |
| cpu_wdata_i | input | 32 | CPU write data in lane position |
| cpu_rvalid_o | output | 1 | CPU read response valid |
| cpu_rdata_o | output | 32 | CPU read data, zero if refused |
| eng_valid_i | input | 1 | Engine beat valid |
| eng_we_i | input | 1 | Engine write (1) or read (0) |
| eng_sel_i | input | 1 | Engine buffer select |
| eng_addr_i | input | 6 | Burst word address, multiple of four |
| eng_beat_i | input | 2 | Beat number within burst |
| eng_last_i | input | 1 | Last beat marker |
| eng_wdata_i | input | 32 | Engine write data |
| eng_rdata_o | output | 32 | Engine read data, one cycle after the beat |
| err_clr_i | input | 2 | Clear pulses: bit 0 CPU error, bit 1 protocol error |
| cpu_err_o | output | 1 | Sticky CPU refusal flag |
| proto_err_o | output | 1 | Sticky burst protocol error flag |
| irq_o | output | 1 | Error interrupt level |

## Verification
The assertions assume that cpu_size_i, cpu_addr_i and the engine fields carry known values while their valid lines are high. They also assume the engine holds eng_addr_i and eng_sel_i for the whole burst. The bench changes these inputs only at falling edges and keeps each burst's address and buffer constant. It still drives deliberately broken beat numbers, last markers and misaligned addresses, because the block must flag those. The bench leaves gaps between beats only where it tests the lockout that outlasts the enable.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int BEATS = 4;
  localparam int BW = $clog2(BEATS);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;
endpackage

// File: rtl/sbuf_mem.sv
module sbuf_mem import sbuf_pkg::*; #(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [NB-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [NB-1:0][7:0] mem_q [WORDS];
  logic [DW-1:0]      rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
    end else if (we_i) begin
      for (int b = 0; b < NB; b++)
        if (be_i[b]) mem_q[waddr_i][b] <= wdata_i[8*b +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sbuf_lockout.sv
module sbuf_lockout import sbuf_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xfer_en_i,
  input  logic          busy_i,
  input  logic          eng_valid_i,
  input  logic          cpu_req_i,
  input  logic [1:0]    cpu_size_i,
  input  logic [1:0]    cpu_ofs_i,
  input  logic          err_clr_i,
  output logic          lock_o,
  output logic          cpu_ok_o,
  output logic [NB-1:0] cpu_be_o,
  output logic          cpu_err_o
);
  size_e sz;
  logic  aligned, refuse, err_q;

  assign sz = size_e'(cpu_size_i);

  always_comb begin
    aligned  = 1'b0;
    cpu_be_o = '0;
    case (sz)
      SZ_BYTE: begin aligned = 1'b1;            cpu_be_o = 4'b0001 << cpu_ofs_i; end
      SZ_HALF: begin aligned = !cpu_ofs_i[0];   cpu_be_o = cpu_ofs_i[1] ? 4'b1100 : 4'b0011; end
      SZ_WORD: begin aligned = (cpu_ofs_i == 2'd0); cpu_be_o = 4'b1111; end
      default: ;
    endcase
  end

  // engine enable, open burst and a live beat all shut the CPU out
  assign lock_o   = xfer_en_i | busy_i | eng_valid_i;
  assign cpu_ok_o = cpu_req_i & aligned & !lock_o;
  assign refuse   = cpu_req_i & !cpu_ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (refuse)    err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign cpu_err_o = err_q;

  p_locked_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && xfer_en_i) |=> cpu_err_o);
  p_misalign_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_size_i == 2'd2 && cpu_ofs_i != 2'd0) |=> cpu_err_o);
  p_err_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_err_o && !err_clr_i) |=> cpu_err_o);
endmodule

// File: rtl/sbuf_burst.sv
module sbuf_burst import sbuf_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [BW-1:0] beat_i,
  input  logic          last_i,
  input  logic [1:0]    ofs_i,
  input  logic          err_clr_i,
  output logic          beat_ok_o,
  output logic          busy_o,
  output logic          proto_err_o
);
  logic [BW-1:0] cnt_q;
  logic          bad, err_q;

  assign bad = valid_i & ((beat_i != cnt_q)
                        | (last_i != (beat_i == BW'(BEATS - 1)))
                        | (ofs_i != 2'd0));
  assign beat_ok_o = valid_i & !bad;
  assign busy_o    = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (bad)       cnt_q <= '0;
    else if (beat_ok_o) cnt_q <= last_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (bad)       err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign proto_err_o = err_q;

  p_early_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i && beat_i != 2'd3) |=> proto_err_o);
  p_open_burst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !busy_o && beat_i == 2'd0 && !last_i && ofs_i == 2'd0) |=> busy_o);
  p_proto_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proto_err_o && !err_clr_i) |=> proto_err_o);
endmodule

// File: rtl/stage_buf_arbiter.sv
module stage_buf_arbiter import sbuf_pkg::*; #(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xfer_en_i,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic          cpu_sel_i,
  input  logic [AW+1:0] cpu_addr_i,
  input  logic [1:0]    cpu_size_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_rvalid_o,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          eng_valid_i,
  input  logic          eng_we_i,
  input  logic          eng_sel_i,
  input  logic [AW-1:0] eng_addr_i,
  input  logic [1:0]    eng_beat_i,
  input  logic          eng_last_i,
  input  logic [DW-1:0] eng_wdata_i,
  output logic [DW-1:0] eng_rdata_o,
  input  logic [1:0]    err_clr_i,
  output logic          cpu_err_o,
  output logic          proto_err_o,
  output logic          irq_o
);
  logic          lock, cpu_ok, busy, beat_ok;
  logic [NB-1:0] cpu_be;
  logic [AW-1:0] cpu_idx, eng_idx;
  logic [DW-1:0] rd_buf [2];
  logic          cpu_rd_ok_q, cpu_rvalid_q, cpu_sel_q, eng_sel_q;

  assign cpu_idx = cpu_addr_i[AW+1:2];
  assign eng_idx = {eng_addr_i[AW-1:2], eng_beat_i};

  sbuf_lockout u_lockout (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .xfer_en_i   (xfer_en_i),
    .busy_i      (busy),
    .eng_valid_i (eng_valid_i),
    .cpu_req_i   (cpu_req_i),
    .cpu_size_i  (cpu_size_i),
    .cpu_ofs_i   (cpu_addr_i[1:0]),
    .err_clr_i   (err_clr_i[0]),
    .lock_o      (lock),
    .cpu_ok_o    (cpu_ok),
    .cpu_be_o    (cpu_be),
    .cpu_err_o   (cpu_err_o)
  );

  sbuf_burst u_burst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (eng_valid_i),
    .beat_i      (eng_beat_i),
    .last_i      (eng_last_i),
    .ofs_i       (eng_addr_i[1:0]),
    .err_clr_i   (err_clr_i[1]),
    .beat_ok_o   (beat_ok),
    .busy_o      (busy),
    .proto_err_o (proto_err_o)
  );

  for (genvar k = 0; k < 2; k++) begin : g_buf
    logic          eng_hit, eng_wr, cpu_wr, we;
    logic [AW-1:0] waddr, raddr;
    logic [NB-1:0] be;
    logic [DW-1:0] wdata;

    assign eng_hit = eng_valid_i & (eng_sel_i == k[0]);
    assign eng_wr  = eng_hit & eng_we_i & beat_ok;
    assign cpu_wr  = cpu_ok & cpu_we_i & (cpu_sel_i == k[0]);
    assign we      = eng_wr | cpu_wr;
    assign waddr   = eng_wr ? eng_idx : cpu_idx;
    assign be      = eng_wr ? '1 : cpu_be;
    assign wdata   = eng_wr ? eng_wdata_i : cpu_wdata_i;
    assign raddr   = eng_hit ? eng_idx : cpu_idx;

    sbuf_mem #(.WORDS(WORDS)) u_mem (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .waddr_i (waddr),
      .be_i    (be),
      .wdata_i (wdata),
      .raddr_i (raddr),
      .rdata_o (rd_buf[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_rd_ok_q  <= 1'b0;
      cpu_rvalid_q <= 1'b0;
      cpu_sel_q    <= 1'b0;
      eng_sel_q    <= 1'b0;
    end else begin
      cpu_rd_ok_q  <= cpu_ok & !cpu_we_i;
      cpu_rvalid_q <= cpu_req_i & !cpu_we_i;
      if (cpu_req_i)   cpu_sel_q <= cpu_sel_i;
      if (eng_valid_i) eng_sel_q <= eng_sel_i;
    end
  end

  assign cpu_rvalid_o = cpu_rvalid_q;
  assign cpu_rdata_o  = cpu_rd_ok_q ? rd_buf[cpu_sel_q] : '0;
  assign eng_rdata_o  = rd_buf[eng_sel_q];
  assign irq_o        = cpu_err_o | proto_err_o;

  p_locked_read_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_we_i && lock) |=> (cpu_rvalid_o && cpu_rdata_o == '0));
  p_beat_blocks_cpu_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && eng_valid_i) |=> cpu_err_o);
endmodule

// File: tb/stage_buf_arbiter_bench.sv
`timescale 1ns/1ps
module stage_buf_arbiter_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        xfer_en = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_sel = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        eng_valid = 1'b0, eng_we = 1'b0, eng_sel = 1'b0, eng_last = 1'b0;
  logic [5:0]  eng_addr = '0;
  logic [1:0]  eng_beat = '0;
  logic [31:0] eng_wdata = '0;
  logic [31:0] eng_rdata;
  logic [1:0]  err_clr = '0;
  logic        cpu_err, proto_err, irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [31:0] mdl [2][64];
  logic [31:0] rd_s, erd_s;
  logic        rv_s;

  always #2.5 clk = ~clk;

  stage_buf_arbiter u_stage_buf_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .xfer_en_i(xfer_en),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_sel_i(cpu_sel), .cpu_addr_i(cpu_addr),
    .cpu_size_i(cpu_size), .cpu_wdata_i(cpu_wdata), .cpu_rvalid_o(cpu_rvalid), .cpu_rdata_o(cpu_rdata),
    .eng_valid_i(eng_valid), .eng_we_i(eng_we), .eng_sel_i(eng_sel), .eng_addr_i(eng_addr),
    .eng_beat_i(eng_beat), .eng_last_i(eng_last), .eng_wdata_i(eng_wdata), .eng_rdata_o(eng_rdata),
    .err_clr_i(err_clr), .cpu_err_o(cpu_err), .proto_err_o(proto_err), .irq_o(irq)
  );

  function automatic logic [31:0] pat(int s, int i);
    return 32'h9E3779B9 * 32'(i + 64 * s + 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input int s, input int baddr, input int sz, input logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_sel = s[0]; cpu_addr = 8'(baddr);
    cpu_size = 2'(sz); cpu_wdata = d;
    @(negedge clk);
    rd_s = cpu_rdata; rv_s = cpu_rvalid;
    cpu_req = 1'b0;
  endtask

  task automatic read_chk(input string tag, input int s, input int i, input logic [31:0] exp);
    cpu_op(1'b0, s, i * 4, 2, '0);
    chk(tag, {rv_s, rd_s[30:0]}, {1'b1, exp[30:0]});
    chk(tag, {31'd0, rd_s[31]}, {31'd0, exp[31]});
  endtask

  task automatic clr(input logic [1:0] m);
    @(negedge clk); err_clr = m;
    @(negedge clk); err_clr = '0;
  endtask

  task automatic eng(input logic we, input int s, input int a, input int b, input logic last, input logic [31:0] d);
    @(negedge clk);
    erd_s = eng_rdata;
    eng_valid = 1'b1; eng_we = we; eng_sel = s[0]; eng_addr = 6'(a);
    eng_beat = 2'(b); eng_last = last; eng_wdata = d;
  endtask

  task automatic eng_idle();
    @(negedge clk);
    erd_s = eng_rdata;
    eng_valid = 1'b0; eng_last = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) for (int i = 0; i < 64; i++) mdl[s][i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 cpu_err", {31'd0, cpu_err}, 32'd0);
    chk("R10 proto_err", {31'd0, proto_err}, 32'd0);
    chk("R10 irq", {31'd0, irq}, 32'd0);
    chk("R10 rvalid/rdata", {31'd0, cpu_rvalid} | cpu_rdata, 32'd0);
    rst_n = 1'b1;
    for (int s = 0; s < 2; s++) for (int i = 0; i < 64; i++) read_chk("R10 cleared word", s, i, 32'd0);

    // R1 word writes across both buffers
    for (int s = 0; s < 2; s++) for (int i = 0; i < 64; i++) begin
      cpu_op(1'b1, s, i * 4, 2, pat(s, i)); mdl[s][i] = pat(s, i);
    end
    for (int s = 0; s < 2; s++) for (int i = 0; i < 64; i++) read_chk("R1 word", s, i, mdl[s][i]);

    // R1 byte and halfword lane sweep
    for (int s = 0; s < 2; s++) for (int i = 0; i < 8; i++) begin
      for (int o = 0; o < 4; o++) begin
        logic [7:0] v = 8'(16 * o + i + 64 * s);
        cpu_op(1'b1, s, i * 4 + o, 0, {4{v}});
        mdl[s][i][8*o +: 8] = v;
        read_chk("R1 byte lane", s, i, mdl[s][i]);
      end
      for (int o = 0; o < 4; o += 2) begin
        logic [15:0] h = 16'hBE00 + 16'(o * 8 + i + 32 * s);
        cpu_op(1'b1, s, i * 4 + o, 1, {2{h}});
        mdl[s][i][8*o +: 16] = h;
        read_chk("R1 half lane", s, i, mdl[s][i]);
      end
    end
    chk("R1 no error", {31'd0, cpu_err}, 32'd0);

    // R2 misaligned accesses refused
    for (int c = 0; c < 6; c++) begin
      int sz = (c < 2) ? 1 : (c < 5) ? 2 : 3;
      int o  = (c == 0) ? 1 : (c == 1) ? 3 : (c < 5) ? c - 1 : 0;
      cpu_op(1'b1, 1, 40 * 4 + o, sz, 32'hDEADBEEF);
      chk("R2 misaligned write flags", {31'd0, cpu_err}, 32'd1);
      cpu_op(1'b0, 1, 40 * 4 + o, sz, '0);
      chk("R2 misaligned read zero", rd_s, 32'd0);
      clr(2'b01);
      chk("R4 cleared", {31'd0, cpu_err}, 32'd0);
      read_chk("R2 word unchanged", 1, 40, mdl[1][40]);
    end

    // R4 refusal wins over clear in the same cycle
    cpu_op(1'b1, 0, 1, 2, 32'h0);
    @(negedge clk); err_clr = 2'b01; cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'd2; cpu_size = 2'd2;
    @(negedge clk); err_clr = '0; cpu_req = 1'b0;
    chk("R4 set beats clear", {31'd0, cpu_err}, 32'd1);
    chk("R4 irq follows", {31'd0, irq}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R4 sticky", {31'd0, cpu_err}, 32'd1);
    clr(2'b01);
    chk("R4 irq low", {31'd0, irq}, 32'd0);

    // R5 engine burst writes into every slot of both buffers
    @(negedge clk); xfer_en = 1'b1;
    for (int s = 0; s < 2; s++) for (int sl = 0; sl < 16; sl++) begin
      for (int b = 0; b < 4; b++) begin
        logic [31:0] d = 32'hC0000000 + 32'(s << 16) + 32'(sl * 4 + b);
        eng(1'b1, s, sl * 4, b, b == 3, d);
        mdl[s][sl * 4 + b] = d;
      end
    end
    eng_idle();
    // R5 engine reads
    for (int s = 0; s < 2; s++) for (int sl = 3; sl < 16; sl += 5) begin
      for (int b = 0; b < 4; b++) begin
        eng(1'b0, s, sl * 4, b, b == 3, '0);
        if (b > 0) chk("R5 engine read", erd_s, mdl[s][sl * 4 + b - 1]);
      end
      eng_idle();
      chk("R5 engine read last", erd_s, mdl[s][sl * 4 + 3]);
    end
    chk("R5 no protocol error", {31'd0, proto_err}, 32'd0);

    // R3 CPU locked out while engine enabled
    cpu_op(1'b1, 0, 5 * 4, 2, 32'h12345678);
    chk("R3 write flags", {31'd0, cpu_err}, 32'd1);
    cpu_op(1'b1, 1, 9 * 4 + 2, 0, 32'hFFFFFFFF);
    cpu_op(1'b0, 0, 5 * 4, 2, '0);
    chk("R3 read zero", {31'(rd_s[31:1]), rd_s[0] | !rv_s}, 32'd0);
    @(negedge clk); xfer_en = 1'b0;
    clr(2'b01);
    read_chk("R3 word untouched", 0, 5, mdl[0][5]);
    read_chk("R3 byte untouched", 1, 9, mdl[1][9]);
    for (int s = 0; s < 2; s++) for (int i = 0; i < 64; i++) read_chk("R5 engine data seen by CPU", s, i, mdl[s][i]);

    // R6 early last on beat 2
    @(negedge clk); xfer_en = 1'b1;
    for (int b = 0; b < 3; b++) eng(1'b1, 0, 8, b, b == 2, 32'hA0000000 + 32'(b));
    eng_idle();
    mdl[0][8] = 32'hA0000000; mdl[0][9] = 32'hA0000001;
    chk("R6 early last flagged", {31'd0, proto_err}, 32'd1);
    chk("R9 irq from protocol", {31'd0, irq}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R9 sticky", {31'd0, proto_err}, 32'd1);
    clr(2'b10);
    chk("R9 cleared", {31'd0, proto_err}, 32'd0);
    // R6 out of sequence
    eng(1'b1, 1, 12, 0, 1'b0, 32'hB0000000);
    eng(1'b1, 1, 12, 2, 1'b0, 32'hB0000002);
    eng_idle();
    mdl[1][12] = 32'hB0000000;
    chk("R6 skipped beat flagged", {31'd0, proto_err}, 32'd1);
    clr(2'b10);
    // R6 misaligned burst address
    eng(1'b1, 1, 21, 0, 1'b0, 32'hBADBAD00);
    eng_idle();
    chk("R6 misaligned start flagged", {31'd0, proto_err}, 32'd1);
    clr(2'b10);
    // R6 beat 3 without last
    for (int b = 0; b < 4; b++) eng(1'b1, 0, 32, b, 1'b0, 32'hD0000000 + 32'(b));
    eng_idle();
    for (int b = 0; b < 3; b++) mdl[0][32 + b] = 32'hD0000000 + 32'(b);
    chk("R6 missing last flagged", {31'd0, proto_err}, 32'd1);
    clr(2'b10);
    @(negedge clk); xfer_en = 1'b0;
    // tracker reset: CPU has access again
    cpu_op(1'b1, 0, 50 * 4, 2, 32'h5A5A5A5A); mdl[0][50] = 32'h5A5A5A5A;
    chk("R6 tracker reset, CPU free", {31'd0, cpu_err}, 32'd0);
    for (int i = 8; i < 12; i++) read_chk("R6 partial burst", 0, i, mdl[0][i]);
    for (int i = 32; i < 36; i++) read_chk("R6 partial burst", 0, i, mdl[0][i]);
    for (int i = 20; i < 24; i++) read_chk("R6 misaligned dropped", 1, i, mdl[1][i]);
    read_chk("R6 first beat kept", 1, 12, mdl[1][12]);
    read_chk("R6 bad beat dropped", 1, 14, mdl[1][14]);
    read_chk("R6 CPU write after", 0, 50, mdl[0][50]);

    // R7 burst outlives the enable
    @(negedge clk); xfer_en = 1'b1;
    eng(1'b1, 1, 44, 0, 1'b0, 32'hE0000000);
    eng(1'b1, 1, 44, 1, 1'b0, 32'hE0000001);
    @(negedge clk); eng_valid = 1'b0; xfer_en = 1'b0;
    cpu_op(1'b1, 1, 60 * 4, 2, 32'h77777777);
    chk("R7 locked mid-burst", {31'd0, cpu_err}, 32'd1);
    eng(1'b1, 1, 44, 2, 1'b0, 32'hE0000002);
    eng(1'b1, 1, 44, 3, 1'b1, 32'hE0000003);
    eng_idle();
    for (int b = 0; b < 4; b++) mdl[1][44 + b] = 32'hE0000000 + 32'(b);
    clr(2'b01);
    cpu_op(1'b1, 1, 60 * 4, 2, 32'h66666666); mdl[1][60] = 32'h66666666;
    chk("R7 free after last", {31'd0, cpu_err}, 32'd0);
    read_chk("R7 CPU write landed", 1, 60, mdl[1][60]);
    for (int b = 0; b < 4; b++) read_chk("R7 burst completed", 1, 44 + b, mdl[1][44 + b]);
    chk("R7 no protocol error", {31'd0, proto_err}, 32'd0);

    // R8 collision with an engine beat while disabled
    @(negedge clk);
    eng_valid = 1'b1; eng_we = 1'b1; eng_sel = 1'b0; eng_addr = 6'd16; eng_beat = 2'd0;
    eng_last = 1'b0; eng_wdata = 32'hF0000000;
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_sel = 1'b0; cpu_addr = 8'(3 * 4); cpu_size = 2'd2;
    cpu_wdata = 32'h11111111;
    @(negedge clk); cpu_req = 1'b0;
    eng_beat = 2'd1; eng_wdata = 32'hF0000001;
    eng(1'b1, 0, 16, 2, 1'b0, 32'hF0000002);
    eng(1'b1, 0, 16, 3, 1'b1, 32'hF0000003);
    eng_idle();
    for (int b = 0; b < 4; b++) mdl[0][16 + b] = 32'hF0000000 + 32'(b);
    chk("R8 collision refused", {31'd0, cpu_err}, 32'd1);
    clr(2'b01);
    read_chk("R8 CPU target untouched", 0, 3, mdl[0][3]);
    for (int b = 0; b < 4; b++) read_chk("R8 engine burst landed", 0, 16 + b, mdl[0][16 + b]);

    finish_run();
  end
endmodule